// File: doc/BRIEF.md
# Byte-to-Halfword Dual-Clock FIFO

This block carries a byte stream from one clock domain into another and hands it out as 16-bit words. The producer presents one byte per write-clock cycle with a write enable. The consumer pulls one 16-bit word per read-clock cycle with a read enable. Each word is built from two bytes that were written one after the other. The two clocks are unrelated, and the write side may run faster than the read side, for example 50 MHz against 25 MHz.

Word storage is an inferred two-port memory of 128 words. The write pointer and the read pointer pass between the domains as Gray code through two-flop synchronizers. Each side works out its own flag and its own fill level from its local pointer and the synchronized remote pointer, so both flags are pessimistic. Each side counts fill in its own unit: bytes on the write side, whole words on the read side. One byte position is kept in reserve, so the block holds at most 255 bytes.

A single active-low asynchronous reset clears the block. Its release is synchronized separately into each domain.

Top module: `pack2_cdc_fifo`

## Requirements
- R1: The write port is 8 bits wide and the read port is 16 bits wide. Of each two consecutively accepted bytes, the earlier one appears in rd_word[15:8] and the later one in rd_word[7:0].
- R2: While arst_n is low, and after its release, the block shows: wr_full = 0, rd_empty = 1, wr_level = 0, rd_level = 0 and rd_word = 0. A lone byte still waiting for its partner when reset comes is discarded.
- R3: A write presented while wr_full is 1 is ignored. It changes neither the stored data nor the write pointer, and wr_level does not rise.
- R4: A read presented while rd_empty is 1 is ignored. rd_word keeps its value and the read pointer does not move.
- R5: Starting from empty, wr_full rises right after the write-clock edge that accepts the 255th unread byte. At that point wr_level reads 255.
- R6: A word becomes readable only after both of its bytes are accepted. While a single odd byte is waiting, rd_empty stays 1 and rd_level does not count it.
- R7: Once both domains have settled, wr_level equals the number of bytes written and not yet read, and rd_level equals the number of complete unread words. wr_level never rises without a write, and rd_level never falls without a read.
- R8: A read accepted at a read-clock edge puts its word on rd_word at that same edge, one cycle after the enable was presented. rd_word then holds until the next accepted read.
- R9: Data leaves in the order it was written, under any mix of enables on the two clocks. Each pointer crossing a domain changes at most one bit per source-clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write request for wr_byte |
| wr_byte | input | 8 | Byte to be stored |
| wr_full | output | 1 | No free byte position, as seen by the write side |
| wr_level | output | 8 | Write-side fill level in bytes |
| rd_en | input | 1 | Read request for the next word |
| rd_word | output | 16 | Registered read word |
| rd_empty | output | 1 | No complete word available, as seen by the read side |
| rd_level | output | 7 | Read-side fill level in whole words |

## Verification
Flags and levels owned by the side that acted change at that side's next clock edge. The bench therefore samples them at the following falling edge of the same clock. A read word is due at the edge that accepts the read, so the bench compares it at the falling edge one read cycle after raising the enable.

Anything that must cross domains needs up to three destination clocks: empty clearing after a write, full clearing after a read, and the levels on the far side. The bench waits six read clocks before comparing those results against its byte-queue model. Acceptance is decided at each falling edge from the flag the block shows at that moment, and that flag cannot change before the next rising edge.

// File: rtl/p2f_pkg.sv
package p2f_pkg;
  // byte lane the next accepted write fills
  typedef enum logic {
    LANE_HI = 1'b0,
    LANE_LO = 1'b1
  } lane_e;
endpackage

// File: rtl/p2f_sync.sv
module p2f_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/p2f_store.sv
module p2f_store #(
  parameter int AW = 7,
  parameter int W  = 16
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/p2f_wr_ctl.sv
module p2f_wr_ctl
  import p2f_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int AW     = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [BYTE_W-1:0]   wr_byte,
  input  logic [AW:0]         rgray_s,
  output logic                full,
  output logic [AW:0]         level,
  output logic                mem_we,
  output logic [AW-1:0]       mem_waddr,
  output logic [2*BYTE_W-1:0] mem_wdata,
  output logic [AW:0]         wgray_q
);
  localparam int PW  = AW + 1;
  localparam int BPW = AW + 2;
  localparam logic [BPW-1:0] CAP_BYTES = BPW'((2 << AW) - 1);

  logic [BPW-1:0]    bptr_q, bptr_n;
  logic [BYTE_W-1:0] hi_q, hi_n;
  logic [PW-1:0]     wgray_n;
  logic [PW-1:0]     rp_bin;
  logic [PW-1:0]     wword_n;
  logic [BPW-1:0]    lvl;
  logic              accept;
  lane_e             lane;

  // Gray to binary for the synchronized read pointer
  always_comb begin
    rp_bin[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      rp_bin[i] = rp_bin[i+1] ^ rgray_s[i];
    end
  end

  always_comb begin
    lvl       = bptr_q - {rp_bin, 1'b0};
    full      = (lvl == CAP_BYTES);
    level     = lvl[AW:0];
    accept    = wr_en && !full;
    lane      = lane_e'(bptr_q[0]);
    mem_waddr = bptr_q[AW:1];
    mem_wdata = {hi_q, wr_byte};
    mem_we    = accept && (lane == LANE_LO);
    hi_n      = (accept && (lane == LANE_HI)) ? wr_byte : hi_q;
    bptr_n    = bptr_q + BPW'(accept);
    wword_n   = bptr_n[BPW-1:1];
    wgray_n   = wword_n ^ (wword_n >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bptr_q  <= '0;
      hi_q    <= '0;
      wgray_q <= '0;
    end else begin
      bptr_q  <= bptr_n;
      hi_q    <= hi_n;
      wgray_q <= wgray_n;
    end
  end
endmodule

// File: rtl/p2f_rd_ctl.sv
module p2f_rd_ctl #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  output logic          empty,
  output logic [AW-1:0] level,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   rgray_q
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rptr_q, rptr_n;
  logic [PW-1:0] rgray_n;
  logic [PW-1:0] wp_bin;
  logic [PW-1:0] lvl;
  logic          accept;

  always_comb begin
    wp_bin[PW-1] = wgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      wp_bin[i] = wp_bin[i+1] ^ wgray_s[i];
    end
  end

  always_comb begin
    lvl       = wp_bin - rptr_q;
    empty     = (lvl == '0);
    level     = lvl[AW-1:0];
    accept    = rd_en && !empty;
    mem_re    = accept;
    mem_raddr = rptr_q[AW-1:0];
    rptr_n    = rptr_q + PW'(accept);
    rgray_n   = rptr_n ^ (rptr_n >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      rgray_q <= '0;
    end else begin
      rptr_q  <= rptr_n;
      rgray_q <= rgray_n;
    end
  end
endmodule

// File: rtl/pack2_cdc_fifo.sv
module pack2_cdc_fifo #(
  parameter int BYTE_W  = 8,
  parameter int WORD_AW = 7
) (
  input  logic                  wr_clk,
  input  logic                  rd_clk,
  input  logic                  arst_n,
  input  logic                  wr_en,
  input  logic [BYTE_W-1:0]     wr_byte,
  output logic                  wr_full,
  output logic [WORD_AW:0]      wr_level,
  input  logic                  rd_en,
  output logic [2*BYTE_W-1:0]   rd_word,
  output logic                  rd_empty,
  output logic [WORD_AW-1:0]    rd_level
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int PW     = WORD_AW + 1;

  logic               wr_rst_n, rd_rst_n;
  logic [PW-1:0]      wr_gray, rd_gray;
  logic [PW-1:0]      wr_gray_s, rd_gray_s;
  logic               mem_we, mem_re;
  logic [WORD_AW-1:0] mem_waddr, mem_raddr;
  logic [WORD_W-1:0]  mem_wdata;

  // reset release synchronized into each domain
  p2f_sync #(.W(1)) u_wrst (
    .clk(wr_clk), .rst_n(arst_n), .d(1'b1), .q(wr_rst_n)
  );
  p2f_sync #(.W(1)) u_rrst (
    .clk(rd_clk), .rst_n(arst_n), .d(1'b1), .q(rd_rst_n)
  );

  // Gray pointers across the domains
  p2f_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s)
  );
  p2f_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  p2f_wr_ctl #(.BYTE_W(BYTE_W), .AW(WORD_AW)) u_wr (
    .clk       (wr_clk),
    .rst_n     (wr_rst_n),
    .wr_en     (wr_en),
    .wr_byte   (wr_byte),
    .rgray_s   (rd_gray_s),
    .full      (wr_full),
    .level     (wr_level),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .wgray_q   (wr_gray)
  );

  p2f_rd_ctl #(.AW(WORD_AW)) u_rd (
    .clk       (rd_clk),
    .rst_n     (rd_rst_n),
    .rd_en     (rd_en),
    .wgray_s   (wr_gray_s),
    .empty     (rd_empty),
    .level     (rd_level),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr),
    .rgray_q   (rd_gray)
  );

  p2f_store #(.AW(WORD_AW), .W(WORD_W)) u_mem (
    .wclk   (wr_clk),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  (mem_wdata),
    .rclk   (rd_clk),
    .rrst_n (rd_rst_n),
    .re     (mem_re),
    .raddr  (mem_raddr),
    .rdata  (rd_word)
  );
endmodule

// File: rtl/p2f_chk.sv
module p2f_chk #(
  parameter int BYTE_W  = 8,
  parameter int WORD_AW = 7
) (
  input logic                wr_clk,
  input logic                rd_clk,
  input logic                wr_rst_n,
  input logic                rd_rst_n,
  input logic                wr_en,
  input logic                wr_full,
  input logic [WORD_AW:0]    wr_level,
  input logic                rd_en,
  input logic                rd_empty,
  input logic [WORD_AW-1:0]  rd_level,
  input logic [2*BYTE_W-1:0] rd_word,
  input logic [WORD_AW:0]    wr_gray,
  input logic [WORD_AW:0]    rd_gray
);
  // R3: a write refused for fullness never raises the byte level
  p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full) |=> (wr_level <= $past(wr_level)));

  // R4: a read refused for emptiness leaves the output word alone
  p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_empty) |=> $stable(rd_word));

  // R7: the byte level only climbs on a write
  p_wr_level_rise_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_en |=> (wr_level <= $past(wr_level)));

  // R7: the word level only drops on a read
  p_rd_level_fall_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |=> (rd_level >= $past(rd_level)));

  // R8: output word held between accepted reads
  p_word_hold_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |=> $stable(rd_word));

  // R6: a nonzero word level never coexists with empty
  p_empty_level_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_level != '0) |-> !rd_empty);

  // R9: Gray pointers move by one bit at most per source clock
  p_wgray_step_r9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  p_rgray_step_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind pack2_cdc_fifo p2f_chk #(.BYTE_W(BYTE_W), .WORD_AW(WORD_AW)) u_chk (
  .wr_clk   (wr_clk),
  .rd_clk   (rd_clk),
  .wr_rst_n (wr_rst_n),
  .rd_rst_n (rd_rst_n),
  .wr_en    (wr_en),
  .wr_full  (wr_full),
  .wr_level (wr_level),
  .rd_en    (rd_en),
  .rd_empty (rd_empty),
  .rd_level (rd_level),
  .rd_word  (rd_word),
  .wr_gray  (wr_gray),
  .rd_gray  (rd_gray)
);

// File: tb/tb_pack2_cdc_fifo.sv
`timescale 1ns / 1ps
module tb_pack2_cdc_fifo;
  logic        wr_clk, rd_clk, arst_n;
  logic        wr_en, rd_en;
  logic [7:0]  wr_byte;
  logic        wr_full, rd_empty;
  logic [7:0]  wr_level;
  logic [6:0]  rd_level;
  logic [15:0] rd_word;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] q[$];

  pack2_cdc_fifo dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n),
    .wr_en(wr_en), .wr_byte(wr_byte), .wr_full(wr_full), .wr_level(wr_level),
    .rd_en(rd_en), .rd_word(rd_word), .rd_empty(rd_empty), .rd_level(rd_level)
  );

  // 200 MHz write clock, 100 MHz read clock, edges never coincide
  initial begin
    wr_clk = 1'b0;
    forever #2.5 wr_clk = ~wr_clk;
  end
  initial begin
    rd_clk = 1'b0;
    #1;
    forever #5 rd_clk = ~rd_clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pack_of(input logic [7:0] a, input logic [7:0] b);
    return {a, b};
  endfunction

  task automatic push_byte(input logic [7:0] b);
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_byte = b;
    if (!wr_full) q.push_back(b);
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic pull_word(input string tag, output bit got);
    logic [15:0] e;
    e = '0;
    @(negedge rd_clk);
    rd_en = 1'b1;
    got = !rd_empty;
    if (got) begin
      e = pack_of(q[0], q[1]);
      void'(q.pop_front());
      void'(q.pop_front());
    end
    @(negedge rd_clk);
    rd_en = 1'b0;
    if (got) chk(tag, rd_word, e);
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
  endtask

  task automatic check_levels(input string tag);
    settle();
    chk({tag, " wr_level"}, wr_level, q.size());
    chk({tag, " rd_level"}, rd_level, q.size() / 2);
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    #1 arst_n = 1'b0;
    q.delete();
    @(negedge wr_clk);
    chk("R2 full in reset", wr_full, 0);
    chk("R2 empty in reset", rd_empty, 1);
    @(negedge wr_clk);
    #1 arst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit got;
    logic [15:0] held;
    void'($urandom(32'd2024));
    arst_n = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    wr_byte = '0;
    #23 arst_n = 1'b1;
    repeat (4) @(negedge rd_clk);

    // R2: reset state
    chk("R2 full", wr_full, 0);
    chk("R2 empty", rd_empty, 1);
    chk("R2 wr_level", wr_level, 0);
    chk("R2 rd_level", rd_level, 0);
    chk("R2 rd_word", rd_word, 0);

    // R6: lone byte stays invisible
    push_byte(8'hA1);
    settle();
    chk("R6 empty with odd byte", rd_empty, 1);
    chk("R6 rd_level with odd byte", rd_level, 0);
    chk("R7 wr_level one byte", wr_level, 1);
    push_byte(8'hB2);
    settle();
    chk("R6 empty after pair", rd_empty, 0);
    chk("R6 rd_level after pair", rd_level, 1);
    pull_word("R1 byte order", got);
    chk("R1 read accepted", got, 1);
    chk("R1 word value", rd_word, 16'hA1B2);

    // R4: read while empty ignored
    settle();
    held = rd_word;
    chk("R4 empty before read", rd_empty, 1);
    pull_word("R4 unexpected read", got);
    chk("R4 read refused", got, 0);
    chk("R4 rd_word held", rd_word, held);
    push_byte(8'h3C);
    push_byte(8'hD4);
    settle();
    pull_word("R4 pointer unchanged", got);
    chk("R4 next word", rd_word, 16'h3CD4);

    // R5 and R3: fill to capacity
    check_levels("R7 idle");
    for (int i = 0; i < 255; i++) begin
      push_byte(8'(i));
      if (i == 253) chk("R5 not full at 254", wr_full, 0);
    end
    chk("R5 full at 255", wr_full, 1);
    chk("R5 wr_level at 255", wr_level, 255);
    push_byte(8'hEE);
    chk("R3 still full", wr_full, 1);
    chk("R3 wr_level unchanged", wr_level, 255);
    chk("R3 byte not queued", q.size(), 255);
    check_levels("R7 full");
    for (int i = 0; i < 127; i++) pull_word("R9 full drain", got);
    check_levels("R7 odd tail");
    push_byte(8'h5A);
    settle();
    pull_word("R3 data after refused write", got);
    chk("R3 tail word", rd_word, 16'hFE5A);

    // R9: random traffic on both clocks
    fork
      begin
        for (int i = 0; i < 3000; i++) begin
          @(negedge wr_clk);
          wr_en = (($urandom % 100) < 60);
          wr_byte = 8'($urandom);
          if (wr_en && !wr_full) q.push_back(wr_byte);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
      end
      begin
        bit pend;
        logic [15:0] e;
        pend = 0;
        e = '0;
        for (int i = 0; i < 1800; i++) begin
          @(negedge rd_clk);
          if (pend) chk("R9 random order", rd_word, e);
          rd_en = ($urandom % 2) == 1;
          pend = rd_en && !rd_empty;
          if (pend) begin
            e = pack_of(q[0], q[1]);
            void'(q.pop_front());
            void'(q.pop_front());
          end
        end
        @(negedge rd_clk);
        if (pend) chk("R9 random order", rd_word, e);
        rd_en = 1'b0;
      end
    join
    check_levels("R7 after random");
    while (q.size() > 1) begin
      settle();
      pull_word("R9 drain", got);
    end
    check_levels("R7 drained");

    // R2: reset drops a waiting odd byte
    push_byte(8'h77);
    do_reset();
    chk("R2 wr_level after reset", wr_level, 0);
    chk("R2 empty after reset", rd_empty, 1);
    chk("R2 rd_word after reset", rd_word, 0);
    push_byte(8'h12);
    push_byte(8'h34);
    settle();
    pull_word("R2 packing restarted", got);
    chk("R2 fresh pair", rd_word, 16'h1234);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule